// File: doc/BRIEF.md
# Single-Channel Word-Copy DMA Engine

The engine is a memory-to-memory copier that a processor sets up through four 32-bit registers in a small window of its address space. Software writes a source address, a destination address and a length in bytes, then writes a go command. The engine then takes over a master port and copies 4-byte words. For every word it issues one read at the source and one write at the destination. Both addresses advance by four after each word. Every word takes the same fixed budget of clock cycles, so the time a transfer takes is known in advance.

When the last word has been written, the engine raises an interrupt line. The line stays high until software writes the control register. A write of 0 only acknowledges the interrupt. A write of 1 acknowledges it and launches the next transfer at once. While a copy is running, the configuration is locked and a status bit reports busy.

Top module: `dma_single_ch`

## Requirements
- R1: The register window is decoded when the upper address bits match the base (default 0x8000) and address bits [1:0] are zero. Offset 0x0 holds the source address, 0x4 the destination address and 0x8 the length in bytes. These three registers read back what was written, except that bits [1:0] of both address registers always read as zero. Accesses outside the window have no effect, and all registers read 0 after reset.
- R2: A write to offset 0xC with bit 0 set, while idle, starts a transfer. A read of offset 0xC returns bit 0 = busy and bit 1 = interrupt pending, with all other bits zero.
- R3: A transfer moves floor(length/4) words. Word i is read from source+4i and written to destination+4i, and no other location is written.
- R4: Each word takes exactly STEP_CYC cycles (default 10). For a transfer of N words, the interrupt rises exactly STEP_CYC*N clock edges after the edge that captured the go write, provided the memory answers within the budget.
- R5: The interrupt stays high until a write to offset 0xC. A write of 0 clears it. A write of 1 clears it and starts a new transfer.
- R6: A length below 4 raises the interrupt on the same edge that captures the go write, issues no memory request and never shows busy.
- R7: While busy, writes to any register, including offset 0xC, are ignored.
- R8: A master request holds its valid, kind and address stable until ready. No request is made while idle, and every request address is word aligned.
- R9: Busy falls only on the edge where the interrupt rises, and the interrupt is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_sel | input | 1 | Slave access strobe |
| s_wr | input | 1 | Slave access is a write |
| s_addr | input | REG_AW | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data (same cycle) |
| m_valid | output | 1 | Master request valid |
| m_we | output | 1 | Master request is a write |
| m_addr | output | AW | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_ready | input | 1 | Memory accepts the request |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| irq | output | 1 | Completion interrupt |

## Verification
Register reads are combinational, so each readback is sampled in the same cycle, a delay after the negative edge. A go write is captured on one rising edge, and the bench counts negative edges from the one that follows. For N words the interrupt must first be seen after exactly 10N counts and not after 10N-1, at which point status must still read busy. For a short length it must be seen at count zero. A clear takes effect on the edge that captures the write, so it is checked at the next negative edge. Copied memory, including the untouched word just past the end, is inspected only after the interrupt.

// File: rtl/dma_pkg.sv
package dma_pkg;
   // register slots, selected by address bits [3:2]
   localparam logic [1:0] SLOT_SRC  = 2'd0;
   localparam logic [1:0] SLOT_DST  = 2'd1;
   localparam logic [1:0] SLOT_LEN  = 2'd2;
   localparam logic [1:0] SLOT_CTRL = 2'd3;

   localparam int GO_BIT   = 0;
   localparam int BUSY_BIT = 0;
   localparam int IRQ_BIT  = 1;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD,
      PH_RWAIT,
      PH_WR,
      PH_PAD
   } phase_t;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
   import dma_pkg::*;
#(
   parameter int               AW     = 32,
   parameter int               LW     = 32,
   parameter int               REG_AW = 16,
   parameter logic [REG_AW-1:0] BASE  = 'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel,
   input  logic              s_wr,
   input  logic [REG_AW-1:0] s_addr,
   input  logic [31:0]       s_wdata,
   input  logic              busy_i,
   input  logic              done_i,
   output logic [AW-1:0]     cfg_src_o,
   output logic [AW-1:0]     cfg_dst_o,
   output logic [LW-1:0]     cfg_len_o,
   output logic              irq_o,
   output logic              start_o,
   output logic [31:0]       rd_data_o
);
   logic       hit;
   logic [1:0] slot;
   logic       wr_ok;

   assign hit   = s_sel && (s_addr[REG_AW-1:4] == BASE[REG_AW-1:4]) && (s_addr[1:0] == 2'b00);
   assign slot  = s_addr[3:2];
   assign wr_ok = hit && s_wr && !busy_i;

   assign start_o = wr_ok && (slot == SLOT_CTRL) && s_wdata[GO_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_src_o <= '0;
         cfg_dst_o <= '0;
         cfg_len_o <= '0;
      end else if (wr_ok) begin
         unique case (slot)
            SLOT_SRC: cfg_src_o <= {s_wdata[AW-1:2], 2'b00};
            SLOT_DST: cfg_dst_o <= {s_wdata[AW-1:2], 2'b00};
            SLOT_LEN: cfg_len_o <= s_wdata[LW-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else if (done_i)
         irq_o <= 1'b1;
      else if (wr_ok && (slot == SLOT_CTRL))
         irq_o <= 1'b0;
   end

   always_comb begin
      rd_data_o = '0;
      if (hit && !s_wr) begin
         unique case (slot)
            SLOT_SRC:  rd_data_o[AW-1:0] = cfg_src_o;
            SLOT_DST:  rd_data_o[AW-1:0] = cfg_dst_o;
            SLOT_LEN:  rd_data_o[LW-1:0] = cfg_len_o;
            default: begin
               rd_data_o[BUSY_BIT] = busy_i;
               rd_data_o[IRQ_BIT]  = irq_o;
            end
         endcase
      end
   end
endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
   parameter int AW = 32,
   parameter int WW = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          adv_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [WW-1:0] words_i,
   output logic [AW-1:0] cur_src_o,
   output logic [AW-1:0] cur_dst_o,
   output logic          zero_o,
   output logic          last_o
);
   localparam logic [AW-1:0] STRIDE = AW'(4);
   localparam logic [WW-1:0] ONE    = WW'(1);

   logic [WW-1:0] left_q;

   assign zero_o = (words_i == '0);
   assign last_o = (left_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_src_o <= '0;
         cur_dst_o <= '0;
         left_q    <= '0;
      end else if (load_i) begin
         cur_src_o <= src_i;
         cur_dst_o <= dst_i;
         left_q    <= words_i;
      end else if (adv_i) begin
         cur_src_o <= cur_src_o + STRIDE;
         cur_dst_o <= cur_dst_o + STRIDE;
         left_q    <= left_q - ONE;
      end
   end
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
   import dma_pkg::*;
#(
   parameter int AW       = 32,
   parameter int STEP_CYC = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          zero_i,
   input  logic          last_i,
   input  logic [AW-1:0] cur_src_i,
   input  logic [AW-1:0] cur_dst_i,
   output logic          m_valid_o,
   output logic          m_we_o,
   output logic [AW-1:0] m_addr_o,
   output logic [31:0]   m_wdata_o,
   input  logic          m_ready_i,
   input  logic          m_rvalid_i,
   input  logic [31:0]   m_rdata_i,
   output logic          load_o,
   output logic          adv_o,
   output logic          done_o,
   output logic          busy_o
);
   localparam int          CW   = $clog2(STEP_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

   phase_t        phase_q;
   logic [CW-1:0] cnt_q;
   logic [31:0]   data_q;
   logic          step_end;

   assign busy_o   = (phase_q != PH_IDLE);
   assign step_end = (phase_q == PH_PAD) && (cnt_q == LAST);
   assign load_o   = start_i;
   assign adv_o    = step_end;
   assign done_o   = (start_i && zero_i) || (step_end && last_i);

   assign m_valid_o = (phase_q == PH_RD) || (phase_q == PH_WR);
   assign m_we_o    = (phase_q == PH_WR);
   assign m_addr_o  = (phase_q == PH_WR) ? cur_dst_i : cur_src_i;
   assign m_wdata_o = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         data_q  <= '0;
      end else begin
         if (phase_q != PH_IDLE && cnt_q != LAST)
            cnt_q <= cnt_q + CW'(1);
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i && !zero_i) begin
                  phase_q <= PH_RD;
                  cnt_q   <= '0;
               end
            end
            PH_RD: begin
               if (m_ready_i)
                  phase_q <= PH_RWAIT;
            end
            PH_RWAIT: begin
               if (m_rvalid_i) begin
                  data_q  <= m_rdata_i;
                  phase_q <= PH_WR;
               end
            end
            PH_WR: begin
               if (m_ready_i)
                  phase_q <= PH_PAD;
            end
            PH_PAD: begin
               if (step_end) begin
                  phase_q <= last_i ? PH_IDLE : PH_RD;
                  cnt_q   <= '0;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_single_ch.sv
module dma_single_ch #(
   parameter int                AW        = 32,
   parameter int                LW        = 32,
   parameter int                REG_AW    = 16,
   parameter logic [REG_AW-1:0] BASE      = 'h8000,
   parameter int                STEP_CYC  = 10,
   parameter bit                RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel,
   input  logic              s_wr,
   input  logic [REG_AW-1:0] s_addr,
   input  logic [31:0]       s_wdata,
   output logic [31:0]       s_rdata,
   output logic              m_valid,
   output logic              m_we,
   output logic [AW-1:0]     m_addr,
   output logic [31:0]       m_wdata,
   input  logic              m_ready,
   input  logic              m_rvalid,
   input  logic [31:0]       m_rdata,
   output logic              irq
);
   localparam int WW = LW - 2;

   initial begin
      if (STEP_CYC < 4)           $fatal(1, "STEP_CYC must be at least 4");
      if (AW < 4 || AW > 32)      $fatal(1, "AW out of range");
      if (LW < 3 || LW > 32)      $fatal(1, "LW out of range");
      if (REG_AW < 5)             $fatal(1, "REG_AW too small");
      if (BASE[3:0] != 4'h0)      $fatal(1, "BASE must be 16-byte aligned");
   end

   logic [AW-1:0] cfg_src_w, cfg_dst_w, cur_src_w, cur_dst_w;
   logic [LW-1:0] cfg_len_w;
   logic          busy_w, done_w, start_w, load_w, adv_w, zero_w, last_w;
   logic [31:0]   rd_w;

   dma_regfile #(.AW(AW), .LW(LW), .REG_AW(REG_AW), .BASE(BASE)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
      .busy_i(busy_w), .done_i(done_w),
      .cfg_src_o(cfg_src_w), .cfg_dst_o(cfg_dst_w), .cfg_len_o(cfg_len_w),
      .irq_o(irq), .start_o(start_w), .rd_data_o(rd_w)
   );

   dma_addr_count #(.AW(AW), .WW(WW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load_i(load_w), .adv_i(adv_w),
      .src_i(cfg_src_w), .dst_i(cfg_dst_w), .words_i(cfg_len_w[LW-1:2]),
      .cur_src_o(cur_src_w), .cur_dst_o(cur_dst_w),
      .zero_o(zero_w), .last_o(last_w)
   );

   dma_sequencer #(.AW(AW), .STEP_CYC(STEP_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_w), .zero_i(zero_w), .last_i(last_w),
      .cur_src_i(cur_src_w), .cur_dst_i(cur_dst_w),
      .m_valid_o(m_valid), .m_we_o(m_we), .m_addr_o(m_addr), .m_wdata_o(m_wdata),
      .m_ready_i(m_ready), .m_rvalid_i(m_rvalid), .m_rdata_i(m_rdata),
      .load_o(load_w), .adv_o(adv_w), .done_o(done_w), .busy_o(busy_w)
   );

   if (RDATA_REG) begin : g_rd_reg
      logic [31:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_w;
      end
      assign s_rdata = rd_q;
   end else begin : g_rd_comb
      assign s_rdata = rd_w;
   end
endmodule

// File: rtl/dma_single_ch_chk.sv
module dma_single_ch_chk #(
   parameter int AW       = 32,
   parameter int LW       = 32,
   parameter int STEP_CYC = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          m_valid,
   input logic          m_we,
   input logic [AW-1:0] m_addr,
   input logic          m_ready,
   input logic          irq,
   input logic          busy,
   input logic          s_sel,
   input logic          s_wr,
   input logic [AW-1:0] cfg_src,
   input logic [AW-1:0] cfg_dst,
   input logic [LW-1:0] cfg_len
);
   localparam int          GW  = $clog2(STEP_CYC + 1);
   localparam logic [GW-1:0] GMAX = GW'(STEP_CYC);

   logic          rd_acc;
   logic [GW-1:0] gap_q;
   logic          seen_q;

   assign rd_acc = m_valid && !m_we && m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (rd_acc) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         if (!busy) seen_q <= 1'b0;
         if (gap_q != GMAX) gap_q <= gap_q + GW'(1);
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_we)); // R8
   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !m_valid); // R8
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> m_addr[1:0] == 2'b00); // R8
   AST_BUSY_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq); // R9
   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy); // R9
   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && s_sel && s_wr |=> $stable(cfg_src) && $stable(cfg_dst) && $stable(cfg_len)); // R7
   AST_STEP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc && seen_q |-> gap_q == GW'(STEP_CYC - 1)); // R4
endmodule

bind dma_single_ch dma_single_ch_chk #(.AW(AW), .LW(LW), .STEP_CYC(STEP_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_ready(m_ready),
   .irq(irq), .busy(busy_w), .s_sel(s_sel), .s_wr(s_wr),
   .cfg_src(cfg_src_w), .cfg_dst(cfg_dst_w), .cfg_len(cfg_len_w)
);

// File: tb/dma_single_ch_tb_top.sv
module dma_single_ch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int STEP       = 10;
   localparam logic [15:0] A_SRC  = 16'h8000;
   localparam logic [15:0] A_DST  = 16'h8004;
   localparam logic [15:0] A_LEN  = 16'h8008;
   localparam logic [15:0] A_CTRL = 16'h800C;
   localparam int NV = 4;
   // src, dst, length, clear-with-0 after done
   localparam logic [31:0] VEC [0:NV-1][0:3] = '{
      '{32'h100, 32'h400, 32'd16, 32'd1},
      '{32'h200, 32'h600, 32'd4,  32'd0},
      '{32'h300, 32'h800, 32'd42, 32'd1},
      '{32'h144, 32'hA00, 32'd8,  32'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_sel = 1'b0, s_wr = 1'b0;
   logic [15:0] s_addr = '0;
   logic [31:0] s_wdata = '0, s_rdata;
   logic        m_valid, m_we, m_ready, m_rvalid;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic        irq;

   int checks = 0, failures = 0;
   int acc_cnt;
   logic wq;
   logic [31:0] mem [0:1023];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_single_ch dut_i (
      .clk(clk), .rst_n(rst_n),
      .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .irq(irq)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'h5A000000 ^ (i * 32'h00010001);
   endfunction

   // memory: one wait cycle before ready, read data one cycle after accept
   assign m_ready = m_valid && wq;
   always @(posedge clk) begin
      if (!rst_n) begin
         wq       <= 1'b0;
         m_rvalid <= 1'b0;
         m_rdata  <= '0;
         acc_cnt  <= 0;
         for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      end else begin
         wq       <= m_valid && !wq;
         m_rvalid <= m_valid && !m_we && m_ready;
         if (m_valid && m_ready) begin
            acc_cnt <= acc_cnt + 1;
            if (m_we) mem[m_addr[11:2]] <= m_wdata;
            else      m_rdata <= mem[m_addr[11:2]];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
      s_sel = 1'b1; s_wr = 1'b1; s_addr = a; s_wdata = d;
      @(negedge clk);
      s_sel = 1'b0; s_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
      s_sel = 1'b1; s_wr = 1'b0; s_addr = a;
      #1;
      d = s_rdata;
      s_sel = 1'b0;
   endtask

   // wait for irq from count k0; expect it first at exp_k
   task automatic wait_irq(input int k0, input int exp_k, input string req);
      int k = k0;
      logic [31:0] d;
      while (!irq && k < 2000) begin
         if (k == exp_k - 1) begin
            bus_read(A_CTRL, d);
            chk("R9 busy before end", d, 32'h1);
         end
         @(negedge clk);
         k++;
      end
      chk(req, k, exp_k);
      bus_read(A_CTRL, d);
      chk("R9 status at end", d, 32'h2);
   endtask

   task automatic check_copy(input logic [31:0] src, input logic [31:0] dst, input int n);
      for (int i = 0; i < n; i++)
         chk("R3 copied word", mem[dst[11:2] + i], pat(int'(src[11:2]) + i));
      chk("R3 word past end untouched", mem[dst[11:2] + n], pat(int'(dst[11:2]) + n));
   endtask

   initial begin
      logic [31:0] d;
      int a0, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R2 irq after reset", irq, 1'b0);
      chk("R8 no request after reset", m_valid, 1'b0);
      bus_read(A_SRC, d);  chk("R1 src reset", d, 0);
      bus_read(A_LEN, d);  chk("R1 len reset", d, 0);
      bus_read(A_CTRL, d); chk("R2 status reset", d, 0);

      // address low bits dropped, outside window ignored
      bus_write(A_SRC, 32'h107);
      bus_read(A_SRC, d); chk("R1 src low bits", d, 32'h104);
      bus_write(16'h9000, 32'h777);
      bus_read(A_SRC, d); chk("R1 outside window", d, 32'h104);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic pend;
         pend = irq;
         bus_write(A_SRC, VEC[v][0]);
         bus_write(A_DST, VEC[v][1]);
         bus_write(A_LEN, VEC[v][2]);
         bus_read(A_DST, d); chk("R1 dst readback", d, VEC[v][1]);
         bus_read(A_LEN, d); chk("R1 len readback", d, VEC[v][2]);
         n  = int'(VEC[v][2] >> 2);
         a0 = acc_cnt;
         bus_write(A_CTRL, 32'h1);
         if (pend) chk("R5 go clears pending irq", irq, 1'b0);
         wait_irq(0, STEP * n, "R4 word timing");
         check_copy(VEC[v][0], VEC[v][1], n);
         chk("R3 access count", acc_cnt - a0, 2 * n);
         chk("R8 idle after done", m_valid, 1'b0);
         @(negedge clk);
         chk("R5 irq held", irq, 1'b1);
         if (VEC[v][3] != 0) begin
            bus_write(A_CTRL, 32'h0);
            chk("R5 write 0 clears", irq, 1'b0);
            bus_read(A_CTRL, d); chk("R2 status idle", d, 0);
         end
      end

      // short length: immediate irq, no memory traffic
      bus_write(A_LEN, 32'd3);
      a0 = acc_cnt;
      bus_write(A_CTRL, 32'h1);
      chk("R6 immediate irq", irq, 1'b1);
      bus_read(A_CTRL, d); chk("R6 never busy", d, 32'h2);
      repeat (20) @(negedge clk);
      chk("R6 no access", acc_cnt - a0, 0);
      bus_write(A_CTRL, 32'h0);

      // writes while busy are ignored
      bus_write(A_SRC, 32'h180);
      bus_write(A_DST, 32'hC00);
      bus_write(A_LEN, 32'd12);
      bus_write(A_CTRL, 32'h1);
      bus_write(A_SRC, 32'hFF0);
      bus_write(A_LEN, 32'd100);
      bus_write(A_CTRL, 32'h1);
      wait_irq(3, STEP * 3, "R7 timing unaffected by writes");
      bus_read(A_SRC, d); chk("R7 src kept", d, 32'h180);
      bus_read(A_LEN, d); chk("R7 len kept", d, 32'd12);
      check_copy(32'h180, 32'hC00, 3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule